// File: doc/BRIEF.md
# Split-Access 64-bit Register Block

This block holds the two 64-bit configuration words of an address translator: a control word and a table-base word. Both words drive the translator at all times through dedicated outputs. Software reaches the words over a register bus. Each bus access is either 64 bits or 32 bits wide, and the halves are laid out big-endian: the lower offset of a word holds its upper half.

A 64-bit access at a word's base offset covers the whole word. A 32-bit access at the base offset covers bits 63:32. Any access at base+4 covers bits 31:0. When an access touches one half, the other half is left as it was. A flush window at 0x10/0x14 accepts writes and returns zero on reads, but it has no action. Every other offset is a sink. Read data is registered and appears one cycle after the request. Reset clears both words, and a cleared control word leaves translation disabled.

Top module: `split_cfg_regs`

## Requirements
- R1: While reset is asserted and right after it, `ctrl_o`, `base_o`, `rdata_o` and `rvalid_o` are all zero.
- R2: A write with `wide_i`=1 at offset 0x0 (control) or 0x8 (base) replaces all 64 bits with `wdata_i`. A read with `wide_i`=1 at those offsets returns the full word.
- R3: A write with `wide_i`=0 at offset 0x0 or 0x8 puts `wdata_i[31:0]` into bits 63:32 and keeps bits 31:0.
- R4: A write at offset 0x4 or 0xC, of either size, puts `wdata_i[31:0]` into bits 31:0 and keeps bits 63:32.
- R5: A read with `wide_i`=0 at 0x0 or 0x8 returns bits 63:32 in `rdata_o[31:0]`, with `rdata_o[63:32]` zero. A read at 0x4 or 0xC, of either size, returns bits 31:0 zero-extended.
- R6: Writes to 0x10 and 0x14 change neither word. Reads from 0x10 and 0x14 return zero.
- R7: A write to any offset outside 0x0, 0x4, 0x8 and 0xC (including unaligned ones) changes nothing. A read from such an offset returns zero.
- R8: `rvalid_o` is high in exactly the cycle after a read request (`req_i`=1, `we_i`=0), and `rdata_o` is valid in that cycle.
- R9: `ctrl_o` and `base_o` show the stored words continuously. A write becomes visible after the clock edge that takes it, and the words hold their value when no write hits them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr_i | input | ADDR_W (5) | Byte offset of the access |
| wdata_i | input | 64 | Write data; 32-bit accesses use bits 31:0 |
| rdata_o | output | 64 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| ctrl_o | output | 64 | Control word to the translator |
| base_o | output | 64 | Table-base word to the translator |

## Verification
Each word is first written with a full 64-bit pattern whose halves differ. Then each half is overwritten on its own, and the test confirms that the untouched half keeps its old bytes. This separates a correct half select from one that swaps or clobbers halves. Reads are issued at base and base+4 with both sizes, which distinguishes the upper-half and lower-half read paths and the zero-extension. Writes and reads are also aimed at the flush window, at the unused offset 0x18 and at unaligned offsets, each after the words hold non-zero data, so that a decoder that aliases offsets shows up as a corrupted word or a non-zero read.

// File: rtl/split_cfg_pkg.sv
package split_cfg_pkg;
   // Which part of a word an access touches
   typedef enum logic [1:0] {
      HALF_NONE = 2'd0,
      HALF_HI   = 2'd1,
      HALF_LO   = 2'd2,
      HALF_ALL  = 2'd3
   } half_sel_e;
endpackage

// File: rtl/split_cfg_decode.sv
module split_cfg_decode
   import split_cfg_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int NUM_REGS   = 2,
   parameter int REG_STRIDE = 8,
   localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wide_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o,
   output half_sel_e         half_o
);
   // Offsets at or above NUM_REGS*REG_STRIDE (flush window and beyond) fall through as no hit
   always_comb begin
      hit_o  = 1'b0;
      idx_o  = '0;
      half_o = HALF_NONE;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr_i == ADDR_W'(i * REG_STRIDE)) begin
            hit_o  = 1'b1;
            idx_o  = IDX_W'(i);
            half_o = wide_i ? HALF_ALL : HALF_HI;
         end else if (addr_i == ADDR_W'(i * REG_STRIDE + REG_STRIDE / 2)) begin
            hit_o  = 1'b1;
            idx_o  = IDX_W'(i);
            half_o = HALF_LO;
         end
      end
   end
endmodule

// File: rtl/split_word_reg.sv
module split_word_reg
   import split_cfg_pkg::*;
#(
   parameter int DATA_W  = 64,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  half_sel_e         mode,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         case (mode)
            HALF_ALL: q <= wdata;
            HALF_HI:  q[DATA_W-1:HALF_W] <= wdata[HALF_W-1:0];
            HALF_LO:  q[HALF_W-1:0]      <= wdata[HALF_W-1:0];
            default:  q <= q;
         endcase
      end
   end

   // R3
   hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == HALF_HI) |=> (q[HALF_W-1:0] == $past(q[HALF_W-1:0])));
   // R4
   lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == HALF_LO) |=> (q[DATA_W-1:HALF_W] == $past(q[DATA_W-1:HALF_W])));
   // R9
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/split_cfg_regs.sv
module split_cfg_regs
   import split_cfg_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 64,
   parameter int REG_STRIDE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic              wide_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] base_o
);
   localparam int NUM_REGS = 2;
   localparam int HALF_W   = DATA_W / 2;
   localparam int IDX_W    = $clog2(NUM_REGS);

   if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be even");
   end
   if ((1 << ADDR_W) < (NUM_REGS + 1) * REG_STRIDE) begin : g_bad_addr
      $error("ADDR_W too narrow for register and flush windows");
   end

   logic             dec_hit;
   logic [IDX_W-1:0] dec_idx;
   half_sel_e        dec_half;
   logic [DATA_W-1:0] word_q [NUM_REGS];
   logic [DATA_W-1:0] rd_next;
   logic              rd_req;

   split_cfg_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_REGS  (NUM_REGS),
      .REG_STRIDE(REG_STRIDE)
   ) decode_i (
      .addr_i(addr_i),
      .wide_i(wide_i),
      .hit_o (dec_hit),
      .idx_o (dec_idx),
      .half_o(dec_half)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      split_word_reg #(.DATA_W(DATA_W)) word_i (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_en(req_i && we_i && dec_hit && (dec_idx == IDX_W'(g))),
         .mode (dec_half),
         .wdata(wdata_i),
         .q    (word_q[g])
      );
   end

   assign ctrl_o = word_q[0];
   assign base_o = word_q[1];
   assign rd_req = req_i && !we_i;

   always_comb begin
      rd_next = '0;
      if (dec_hit) begin
         case (dec_half)
            HALF_ALL: rd_next = word_q[dec_idx];
            HALF_HI:  rd_next = {{HALF_W{1'b0}}, word_q[dec_idx][DATA_W-1:HALF_W]};
            HALF_LO:  rd_next = {{HALF_W{1'b0}}, word_q[dec_idx][HALF_W-1:0]};
            default:  rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= rd_req;
         if (rd_req) begin
            rdata_o <= rd_next;
         end
      end
   end

   // R8
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rvalid_o);
   // R8
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rvalid_o);
   // R7
   sink_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && we_i && !dec_hit) |=> ($stable(ctrl_o) && $stable(base_o)));
   // R6
   sink_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dec_hit) |=> (rdata_o == '0));
endmodule

// File: tb/split_cfg_regs_tb.sv
module split_cfg_regs_tb_top;
   localparam int ADDR_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_i = 1'b0;
   logic              we_i = 1'b0;
   logic              wide_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [63:0]       wdata_i = '0;
   logic [63:0]       rdata_o;
   logic              rvalid_o;
   logic [63:0]       ctrl_o;
   logic [63:0]       base_o;

   int checks = 0;
   int fails  = 0;
   logic [63:0] ctrl_m = '0;
   logic [63:0] base_m = '0;
   logic [63:0] exp_q[$];
   string       tag_q[$];
   bit          done = 1'b0;

   always #10 clk = ~clk;

   split_cfg_regs dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .wide_i(wide_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
      .ctrl_o(ctrl_o), .base_o(base_o)
   );

   task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] model_read(logic [ADDR_W-1:0] a, logic w);
      case (a)
         5'h00: return w ? ctrl_m : {32'h0, ctrl_m[63:32]};
         5'h04: return {32'h0, ctrl_m[31:0]};
         5'h08: return w ? base_m : {32'h0, base_m[63:32]};
         5'h0C: return {32'h0, base_m[31:0]};
         default: return 64'h0;
      endcase
   endfunction

   function automatic void model_write(logic [ADDR_W-1:0] a, logic w, logic [63:0] d);
      case (a)
         5'h00: if (w) ctrl_m = d; else ctrl_m[63:32] = d[31:0];
         5'h04: ctrl_m[31:0] = d[31:0];
         5'h08: if (w) base_m = d; else base_m[63:32] = d[31:0];
         5'h0C: base_m[31:0] = d[31:0];
         default: ;
      endcase
   endfunction

   // Driver: write, then check both outputs after the edge that took it
   task automatic do_write(string tag, logic [ADDR_W-1:0] a, logic w, logic [63:0] d);
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b1; wide_i = w; addr_i = a; wdata_i = d;
      model_write(a, w, d);
      @(negedge clk);
      req_i = 1'b0; we_i = 1'b0;
      check64(tag, "ctrl_o", ctrl_o, ctrl_m);
      check64(tag, "base_o", base_o, base_m);
   endtask

   // Driver: read, push expected item for the monitor
   task automatic do_read(string tag, logic [ADDR_W-1:0] a, logic w);
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; wide_i = w; addr_i = a;
      exp_q.push_back(model_read(a, w));
      tag_q.push_back(tag);
      @(negedge clk);
      req_i = 1'b0;
   endtask

   // Monitor: pops one expected item per valid read beat (R8)
   always @(negedge clk) begin
      if (rst_n && rvalid_o) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R8 unexpected rvalid: actual 1 expected 0");
         end else begin
            check64(tag_q.pop_front(), "rdata_o", rdata_o, exp_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check64("R1", "ctrl_o", ctrl_o, 64'h0);
      check64("R1", "base_o", base_o, 64'h0);
      check64("R1", "rdata_o", rdata_o, 64'h0);
      check64("R1", "rvalid_o", {63'h0, rvalid_o}, 64'h0);
      rst_n = 1'b1;

      // R2 full writes and reads
      do_write("R2", 5'h00, 1'b1, 64'h1122_3344_5566_7788);
      do_write("R2", 5'h08, 1'b1, 64'hA1B2_C3D4_E5F6_0718);
      do_read ("R2", 5'h00, 1'b1);
      do_read ("R2", 5'h08, 1'b1);
      // R5 half reads
      do_read ("R5", 5'h00, 1'b0);
      do_read ("R5", 5'h04, 1'b0);
      do_read ("R5", 5'h0C, 1'b1);
      do_read ("R5", 5'h08, 1'b0);
      // R3 upper-half writes
      do_write("R3", 5'h00, 1'b0, 64'hFFFF_FFFF_DEAD_BEEF);
      do_write("R3", 5'h08, 1'b0, 64'h0000_0000_CAFE_F00D);
      do_read ("R3", 5'h00, 1'b1);
      // R4 lower-half writes, both sizes
      do_write("R4", 5'h04, 1'b0, 64'h0000_0000_0BAD_F00D);
      do_write("R4", 5'h0C, 1'b1, 64'h5555_5555_1234_5678);
      do_read ("R4", 5'h08, 1'b1);
      do_read ("R4", 5'h04, 1'b1);
      // R6 flush window
      do_write("R6", 5'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      do_write("R6", 5'h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      do_read ("R6", 5'h10, 1'b1);
      do_read ("R6", 5'h14, 1'b0);
      // R7 other offsets
      do_write("R7", 5'h18, 1'b1, 64'h0123_4567_89AB_CDEF);
      do_write("R7", 5'h02, 1'b0, 64'h0123_4567_89AB_CDEF);
      do_write("R7", 5'h0E, 1'b1, 64'h0123_4567_89AB_CDEF);
      do_read ("R7", 5'h1C, 1'b1);
      do_read ("R7", 5'h01, 1'b1);
      do_read ("R7", 5'h09, 1'b0);
      // R9 words hold across reads and idle cycles
      repeat (4) @(negedge clk);
      check64("R9", "ctrl_o", ctrl_o, ctrl_m);
      check64("R9", "base_o", base_o, base_m);

      @(negedge clk);
      // R8 every read produced exactly one beat
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R8 missing read beats: actual %0d pending expected 0", exp_q.size());
      end
      // R1 reset again clears the words
      rst_n = 1'b0;
      ctrl_m = '0; base_m = '0;
      @(negedge clk);
      check64("R1", "ctrl_o", ctrl_o, 64'h0);
      check64("R1", "base_o", base_o, 64'h0);
      check64("R1", "rvalid_o", {63'h0, rvalid_o}, 64'h0);
      done = 1'b1;
      finish_run();
   end
endmodule